// File: doc/BRIEF.md
# Second-Order Digital Phase Controller for Clock Recovery

This block is the digital loop filter of a clock and data recovery lane. It runs on the lane's half-bit-rate clock. On every cycle it takes an early flag and a late flag from a bang-bang phase detector. It sends single-cycle advance and delay step pulses to a phase-rotating timing vernier.

The filter has two paths. The proportional path is an up/down vote accumulator with a programmable limit. When the net vote reaches the limit, it issues one step and starts again from zero. The integral path has its own vote accumulator, which acts as a pre-filter. Each time that accumulator trips, a signed frequency code moves one step and saturates at plus or minus seven. A binary rate multiplier turns the code magnitude into a steady train of steps, and the code sign sets their direction. The steady train removes nearly all of a constant frequency offset. This means the proportional limit can be made large for strong jitter filtering without losing drift tolerance.

A merge stage adds the two step streams. Opposite steps in the same cycle cancel. Same-direction steps that cannot all be sent in one cycle are held in a small backlog and sent later.

Top module: `cdr_phase_ctrl`

## Requirements
- R1: A cycle counts as an early vote only when `early_i`=1 and `late_i`=0, and as a late vote only when `late_i`=1 and `early_i`=0. A cycle with both flags high or both low changes no state and produces no step.
- R2: The proportional accumulator adds one per early vote and subtracts one per late vote. When the count reaches +L (L = `ph_limit_i`, with 0 treated as 1), exactly one delay step (`step_dly_o`=1) appears two cycles after the vote that completed the count, and the count restarts at zero. Reaching -L gives an advance step (`step_adv_o`=1) in the same way.
- R3: The pre-filter accumulator works the same way with limit `fr_limit_i` (0 treated as 1). Its early-side trip raises `freq_code_o` by one and its late-side trip lowers it by one. The new code is visible two cycles after the vote that tripped it. The code never changes without such a vote and never moves by more than one per cycle.
- R4: `freq_code_o` is a 4-bit two's complement value that saturates at +7 and -7 without wrapping.
- R5: With code magnitude m, the integral path emits exactly m steps in every window of 64 consecutive cycles. A positive code gives delay steps and a negative code gives advance steps.
- R6: `step_adv_o` and `step_dly_o` are never high in the same cycle.
- R7: An advance from one path and a delay from the other in the same cycle cancel, so no step is output. Same-direction steps from both paths are all delivered, the surplus one cycle or more later.
- R8: An active-low `rst_n` asynchronously clears both accumulators, the frequency code, the rate counter, the backlog and both outputs.
- R9: Under a constant drift of 5 steps per 64 cycles, the closed loop settles with `freq_code_o` within one of +5, and the net delay step count over 1280 cycles stays within 8 of 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| early_i | input | 1 | Phase detector: clock early |
| late_i | input | 1 | Phase detector: clock late |
| ph_limit_i | input | 10 | Proportional accumulator limit |
| fr_limit_i | input | 10 | Pre-filter accumulator limit |
| step_adv_o | output | 1 | Advance vernier by one step |
| step_dly_o | output | 1 | Delay vernier by one step |
| freq_code_o | output | 4 | Signed frequency code |

## Verification
A proportional step is due exactly two cycles after the vote that completes the count. A frequency code change is also due two cycles after its tripping vote. The scoreboard stamps each expected step with that cycle number, and the monitor requires a match at that cycle and silence everywhere else while the integral path is idle. Integral-path rates, cancellation and backlog delivery are timed only to within a cycle, so they are counted over whole 64-cycle multiples, and a one-step margin is allowed where a backlog can straddle a window edge. The closed-loop check runs a drift model for 200 rate periods and then measures only the last 20.

// File: rtl/cdr_pc_pkg.sv
package cdr_pc_pkg;

  typedef enum logic [1:0] {
    VOTE_NONE  = 2'd0,
    VOTE_EARLY = 2'd1,
    VOTE_LATE  = 2'd2
  } vote_e;

  typedef struct packed {
    logic adv;
    logic dly;
  } step_t;

  // Exactly one flag high forms a vote; agreement of the flags is no information.
  function automatic vote_e decode_vote(input logic early, input logic late);
    if (early && !late) return VOTE_EARLY;
    if (late && !early) return VOTE_LATE;
    return VOTE_NONE;
  endfunction

endpackage

// File: rtl/cdr_vote_accum.sv
module cdr_vote_accum
  import cdr_pc_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vote_e            vote_i,
  input  logic [CNT_W-1:0] limit_i,
  output step_t            step_o
);

  localparam int ACC_W = CNT_W + 2;
  localparam logic signed [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

  logic signed [ACC_W-1:0] acc_q, acc_d, acc_inc, lim;
  logic                    acc_en;
  step_t                   step_d, step_q;

  always_comb begin
    lim     = (limit_i == '0) ? ONE : $signed({2'b00, limit_i});
    acc_en  = (vote_i != VOTE_NONE);
    acc_inc = acc_q;
    step_d  = '0;
    case (vote_i)
      VOTE_EARLY: acc_inc = acc_q + ONE;
      VOTE_LATE:  acc_inc = acc_q - ONE;
      default:    acc_inc = acc_q;
    endcase
    acc_d = acc_inc;
    if (vote_i == VOTE_EARLY && acc_inc >= lim) begin
      step_d.dly = 1'b1;
      acc_d      = '0;
    end else if (vote_i == VOTE_LATE && acc_inc <= -lim) begin
      step_d.adv = 1'b1;
      acc_d      = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      step_q <= '0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      step_q <= step_d;
    end
  end

  assign step_o = step_q;

endmodule

// File: rtl/cdr_freq_reg.sv
module cdr_freq_reg
  import cdr_pc_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int CODE_MAX = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  step_t                    bump_i,
  output logic signed [CODE_W-1:0] code_o
);

  localparam logic signed [CODE_W-1:0] TOP = CODE_W'(CODE_MAX);
  localparam logic signed [CODE_W-1:0] BOT = -TOP;
  localparam logic signed [CODE_W-1:0] ONE = {{(CODE_W-1){1'b0}}, 1'b1};

  logic signed [CODE_W-1:0] code_q, code_d;
  logic                     code_en;

  always_comb begin
    code_d  = code_q;
    code_en = 1'b0;
    if (bump_i.dly && code_q < TOP) begin
      code_d  = code_q + ONE;
      code_en = 1'b1;
    end else if (bump_i.adv && code_q > BOT) begin
      code_d  = code_q - ONE;
      code_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;

endmodule

// File: rtl/cdr_rate_gen.sv
module cdr_rate_gen
  import cdr_pc_pkg::*;
#(
  parameter int RATE_W = 6,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [CODE_W-1:0] code_i,
  output step_t                    step_o
);

  localparam int MAG_W = CODE_W - 1;
  localparam int PRE_W = RATE_W - MAG_W;

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic [MAG_W-1:0]  upper, fire, sel, mag;
  logic              pre_tick, hit, neg;
  step_t             step_d, step_q;

  assign cnt_en = 1'b1;
  assign cnt_d  = cnt_q + 1'b1;
  assign upper  = cnt_q[RATE_W-1:PRE_W];

  generate
    if (PRE_W > 0) begin : g_pre
      assign pre_tick = &cnt_q[PRE_W-1:0];
    end else begin : g_nopre
      assign pre_tick = 1'b1;
    end
  endgenerate

  // Tap j fires when upper bit j rises; distinct taps never coincide.
  generate
    for (genvar j = 0; j < MAG_W; j++) begin : g_tap
      if (j == 0) begin : g_lsb
        assign fire[j] = pre_tick & ~upper[0];
      end else begin : g_hi
        assign fire[j] = pre_tick & ~upper[j] & (&upper[j-1:0]);
      end
      assign sel[j] = fire[j] & mag[MAG_W-1-j];
    end
  endgenerate

  always_comb begin
    neg        = code_i[CODE_W-1];
    mag        = neg ? (~code_i[MAG_W-1:0] + 1'b1) : code_i[MAG_W-1:0];
    hit        = |sel;
    step_d.dly = hit & ~neg;
    step_d.adv = hit & neg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      step_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      step_q <= step_d;
    end
  end

  assign step_o = step_q;

endmodule

// File: rtl/cdr_step_merge.sv
module cdr_step_merge
  import cdr_pc_pkg::*;
#(
  parameter int BL_W = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  step_t a_i,
  input  step_t b_i,
  output step_t step_o
);

  localparam int SUM_W = BL_W + 2;
  localparam logic signed [SUM_W-1:0] BL_MAX = SUM_W'((1 << (BL_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] BL_MIN = -BL_MAX;
  localparam logic signed [SUM_W-1:0] ONE    = {{(SUM_W-1){1'b0}}, 1'b1};

  logic signed [BL_W-1:0]  bl_q, bl_d;
  logic signed [SUM_W-1:0] sum, rem, up, dn;
  step_t                   step_d, step_q;

  always_comb begin
    up     = SUM_W'(a_i.dly) + SUM_W'(b_i.dly);
    dn     = SUM_W'(a_i.adv) + SUM_W'(b_i.adv);
    sum    = {{(SUM_W-BL_W){bl_q[BL_W-1]}}, bl_q} + up - dn;
    step_d = '0;
    rem    = sum;
    if (sum > 0) begin
      step_d.dly = 1'b1;
      rem        = sum - ONE;
    end else if (sum < 0) begin
      step_d.adv = 1'b1;
      rem        = sum + ONE;
    end
    if (rem > BL_MAX)      rem = BL_MAX;
    else if (rem < BL_MIN) rem = BL_MIN;
    bl_d = rem[BL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q   <= '0;
      step_q <= '0;
    end else begin
      bl_q   <= bl_d;
      step_q <= step_d;
    end
  end

  assign step_o = step_q;

endmodule

// File: rtl/cdr_phase_ctrl.sv
module cdr_phase_ctrl
  import cdr_pc_pkg::*;
#(
  parameter int PH_W     = 10,
  parameter int FR_W     = 10,
  parameter int RATE_W   = 6,
  parameter int CODE_W   = 4,
  parameter int CODE_MAX = 7,
  parameter int BL_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     early_i,
  input  logic                     late_i,
  input  logic [PH_W-1:0]          ph_limit_i,
  input  logic [FR_W-1:0]          fr_limit_i,
  output logic                     step_adv_o,
  output logic                     step_dly_o,
  output logic signed [CODE_W-1:0] freq_code_o
);

  vote_e                    vote;
  step_t                    ph_step, pre_step, fr_step, out_step;
  logic signed [CODE_W-1:0] code;

  assign vote = decode_vote(early_i, late_i);

  cdr_vote_accum #(.CNT_W(PH_W)) u_ph_acc (
    .clk(clk), .rst_n(rst_n), .vote_i(vote), .limit_i(ph_limit_i), .step_o(ph_step)
  );

  cdr_vote_accum #(.CNT_W(FR_W)) u_pre_acc (
    .clk(clk), .rst_n(rst_n), .vote_i(vote), .limit_i(fr_limit_i), .step_o(pre_step)
  );

  cdr_freq_reg #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_freq (
    .clk(clk), .rst_n(rst_n), .bump_i(pre_step), .code_o(code)
  );

  cdr_rate_gen #(.RATE_W(RATE_W), .CODE_W(CODE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .code_i(code), .step_o(fr_step)
  );

  cdr_step_merge #(.BL_W(BL_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .a_i(ph_step), .b_i(fr_step), .step_o(out_step)
  );

  assign step_adv_o  = out_step.adv;
  assign step_dly_o  = out_step.dly;
  assign freq_code_o = code;

endmodule

// File: rtl/cdr_phase_ctrl_chk.sv
module cdr_phase_ctrl_chk #(
  parameter int CODE_W   = 4,
  parameter int CODE_MAX = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     early_i,
  input logic                     late_i,
  input logic                     step_adv_o,
  input logic                     step_dly_o,
  input logic signed [CODE_W-1:0] freq_code_o
);

  localparam logic signed [CODE_W-1:0] TOP = CODE_W'(CODE_MAX);
  localparam logic signed [CODE_W-1:0] BOT = -TOP;

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_adv_o && step_dly_o)); // R6

  AST_CODE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code_o <= TOP) && (freq_code_o >= BOT)); // R4

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freq_code_o) == TOP) |-> (freq_code_o >= TOP - 1)); // R4

  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freq_code_o) == BOT) |-> (freq_code_o <= BOT + 1)); // R4

  AST_CODE_UNIT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code_o == $past(freq_code_o)) || (freq_code_o == $past(freq_code_o) + 1) ||
    (freq_code_o == $past(freq_code_o) - 1)); // R3

  AST_CODE_NEEDS_VOTE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(early_i == late_i, 2) |-> $stable(freq_code_o)); // R3

endmodule

bind cdr_phase_ctrl cdr_phase_ctrl_chk #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .early_i(early_i), .late_i(late_i),
  .step_adv_o(step_adv_o), .step_dly_o(step_dly_o), .freq_code_o(freq_code_o)
);

// File: tb/cdr_phase_ctrl_tb.sv
module cdr_phase_ctrl_tb;

  typedef struct {
    int    due;
    bit    adv;
    bit    dly;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              early = 1'b0, late = 1'b0;
  logic [9:0]        ph_lim = 10'd4, fr_lim = 10'd1023;
  logic              adv, dly;
  logic signed [3:0] code;

  int   cyc = 0, checks = 0, errors = 0, unexp = 0;
  int   ws = -1, we = -2, advc = 0, dlyc = 0;
  bit   strict = 1'b0, done = 1'b0;
  exp_t q[$];

  cdr_phase_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .early_i(early), .late_i(late),
    .ph_limit_i(ph_lim), .fr_limit_i(fr_lim),
    .step_adv_o(adv), .step_dly_o(dly), .freq_code_o(code)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard at the due cycle, flags stray steps, counts windows.
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (adv != e.adv || dly != e.dly) begin
          errors++;
          $display("FAIL %s actual adv=%0b dly=%0b expected adv=%0b dly=%0b",
                   e.tag, adv, dly, e.adv, e.dly);
        end
      end else if (strict && (adv || dly)) begin
        unexp++;
        $display("FAIL R2 stray step at cycle %0d actual adv=%0b dly=%0b expected 0 0",
                 cyc, adv, dly);
      end
      if (cyc >= ws && cyc <= we) begin
        if (adv) advc++;
        if (dly) dlyc++;
      end
    end
  end

  task automatic vote(input bit e, input bit l, input bit xa, input bit xd, input string tag);
    @(negedge clk);
    early = e;
    late  = l;
    if (xa || xd) q.push_back('{cyc + 2, xa, xd, tag});
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    early = 1'b0;
    late  = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    early = 1'b0;
    late  = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Moves the code by single-vote trips; proportional steps produced meanwhile are ignored.
  task automatic set_code(input int c);
    ph_lim = 10'd1;
    fr_lim = 10'd1;
    for (int i = 0; i < (c < 0 ? -c : c); i++) vote(c > 0, c < 0, 0, 0, "");
    idle(4);
    fr_lim = 10'd1023;
    idle(20);
  endtask

  task automatic open_window(input int start, input int len);
    ws   = start;
    we   = start + len - 1;
    advc = 0;
    dlyc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int e_ph, acc;
    repeat (3) @(negedge clk);
    chk(adv == 0 && dly == 0, "R8 outputs in reset", {adv, dly}, 0);
    chk(code == 0, "R8 code in reset", code, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Proportional path with exact timing
    strict = 1'b1;
    ph_lim = 10'd4;
    fr_lim = 10'd1023;
    repeat (3) vote(1, 0, 0, 0, "");
    vote(1, 0, 0, 1, "R2 delay at +4");
    repeat (3) vote(0, 1, 0, 0, "");
    vote(0, 1, 1, 0, "R2 advance at -4");
    repeat (10) vote(1, 1, 0, 0, "");
    repeat (3) vote(1, 0, 0, 0, "");
    vote(1, 0, 0, 1, "R1 both-high votes ignored");
    for (int i = 0; i < 10; i++) begin
      vote(1, 0, 0, 0, "");
      vote(0, 1, 0, 0, "");
    end
    ph_lim = 10'd0;
    vote(0, 1, 1, 0, "R2 zero limit as one (adv)");
    vote(1, 0, 0, 1, "R2 zero limit as one (dly)");
    idle(6);
    chk(unexp == 0, "R2 no stray steps", unexp, 0);
    chk(code == 0, "R1 code unmoved", code, 0);
    strict = 1'b0;

    // Frequency code timing and saturation
    do_reset();
    ph_lim = 10'd1023;
    fr_lim = 10'd2;
    vote(1, 0, 0, 0, "");
    vote(1, 0, 0, 0, "");
    idle(1);
    chk(code == 0, "R3 code not yet moved", code, 0);
    @(negedge clk);
    chk(code == 1, "R3 code +1 two cycles after trip", code, 1);
    fr_lim = 10'd1;
    repeat (10) vote(1, 0, 0, 0, "");
    idle(3);
    chk(code == 7, "R4 saturate at +7", code, 7);
    repeat (16) vote(0, 1, 0, 0, "");
    idle(3);
    chk(code == -7, "R4 saturate at -7", code, -7);
    vote(1, 0, 0, 0, "");
    idle(3);
    chk(code == -6, "R4 leaves -7 by one", code, -6);

    // Rate generator
    do_reset();
    set_code(3);
    chk(code == 3, "R5 code set to +3", code, 3);
    open_window(cyc + 1, 640);
    idle(642);
    chk(dlyc == 30, "R5 delay steps for +3", dlyc, 30);
    chk(advc == 0, "R5 no advance for +3", advc, 0);
    set_code(-6);
    open_window(cyc + 1, 640);
    idle(642);
    chk(advc == 30, "R5 advance steps for -3", advc, 30);
    chk(dlyc == 0, "R5 no delay for -3", dlyc, 0);

    // Async reset mid-cycle
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk(code == 0, "R8 async clear of code", code, 0);
    chk(adv == 0 && dly == 0, "R8 async clear of steps", {adv, dly}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // Cancellation: proportional advances against integral delays
    do_reset();
    set_code(7);
    ph_lim = 10'd1;
    @(negedge clk);
    open_window(cyc + 2, 640);
    early = 1'b0;
    late  = 1'b1;
    repeat (639) @(negedge clk);
    idle(4);
    chk(advc >= 569 && advc <= 571, "R7 opposite steps cancel", advc, 570);
    chk(dlyc == 0, "R7 no delay leaks", dlyc, 0);

    // Same direction: surplus deferred, not lost
    do_reset();
    set_code(-7);
    ph_lim = 10'd2;
    @(negedge clk);
    open_window(cyc + 2, 640);
    early = 1'b0;
    late  = 1'b1;
    repeat (639) @(negedge clk);
    idle(4);
    chk(advc >= 389 && advc <= 391, "R7 same-direction steps all delivered", advc, 390);
    chk(dlyc == 0, "R7 no delay in same-direction run", dlyc, 0);

    // Closed loop with constant drift of 5 steps per 64 cycles
    do_reset();
    ph_lim = 10'd4;
    fr_lim = 10'd8;
    e_ph = 0;
    acc  = 0;
    for (int i = 0; i < 12800; i++) begin
      @(negedge clk);
      if (i == 11520) open_window(cyc, 1280);
      if (dly) e_ph--;
      if (adv) e_ph++;
      acc += 5;
      if (acc >= 64) begin
        acc -= 64;
        e_ph++;
      end
      early = (e_ph > 0);
      late  = (e_ph < 0);
    end
    idle(2);
    chk(code >= 4 && code <= 6, "R9 code settles near +5", code, 5);
    chk(dlyc - advc >= 92 && dlyc - advc <= 108, "R9 net step rate tracks drift",
        dlyc - advc, 100);
    chk(e_ph >= -8 && e_ph <= 8, "R9 phase error bounded", e_ph, 0);
    chk(!(adv && dly), "R6 single direction", {adv, dly}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule